// File: doc/BRIEF.md
# Dual-Mode Measurement Sequencer with Charge Accumulator

This block sequences work on one shared sigma-delta converter for a battery monitor. It runs from a slow time-base strobe, nominally 32768 per second. It decides which of three channels the converter samples next: cell current, cell voltage or die temperature.

In the mixed power mode, current conversions run back to back. A voltage slot is inserted once per measurement frame, nominally 4 s. A temperature slot is inserted once every fourth frame, directly after that frame's voltage slot. In the power-saving mode no current is sampled and the converter sits idle between those slots.

Every current result that completes is sign-extended and added to a charge accumulator, and a 16-bit conversion counter steps by one. The visible current register is refreshed only once per frame. It takes the most recent current result at the moment the voltage slot is launched. A configuration side sets the mode and run bits and can zero the counter. The converter itself is outside the block and is reached through a start/done handshake that carries a channel code.

Top module: `meas_sequencer`

## Requirements
- R1: After reset the mode bit reads 1 (power saving) and the run bit reads 0. The accumulator, the conversion counter and the current, voltage and temperature registers all read 0, and no conversion is started.
- R2: In mixed mode (mode 0) with run 1, when no voltage or temperature slot is pending, a new current conversion starts on the second clock after the cycle in which the previous conversion's done was seen.
- R3: A voltage slot becomes due every FRAME_SEC × TICKS_PER_SEC time-base strobes counted while running. One is also due at reset, so the first conversion after run is set is a voltage conversion. A conversion already in flight is never cut short by a due slot.
- R4: On every TEMP_EVERY-th frame a temperature conversion starts directly after the voltage conversion. In mixed mode the next conversion after it is a current conversion.
- R5: With mode 1 no current conversion is ever started, and the accumulator and the counter do not change.
- R6: Each current result that completes while running is added to the accumulator as a two's complement value sign-extended to ACC_W bits. The counter advances by one, modulo 2^CNT_W.
- R7: When a voltage conversion starts, the current register takes the latest current result, provided a current conversion has completed since the previous copy. Otherwise the current register holds its value.
- R8: The voltage and temperature registers take the result of each voltage or temperature conversion that completes while running.
- R9: With run 0, no conversion starts and the frame timer, accumulator and counter hold. A result that arrives while run is 0 is discarded.
- R10: A pulse on the counter-clear input zeroes the counter on the next clock. It wins over a simultaneous increment and leaves the accumulator untouched.
- R11: The start strobe lasts one clock. Its channel code is 0 for current, 1 for voltage and 2 for temperature, and code 3 is never issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Time-base strobe, TICKS_PER_SEC per second |
| cfgWr | input | 1 | Loads cfgMode and cfgRun |
| cfgMode | input | 1 | 0 mixed, 1 power saving |
| cfgRun | input | 1 | 1 operate, 0 standby |
| cntClr | input | 1 | Counter-clear pulse |
| convStart | output | 1 | One-cycle conversion request |
| convChan | output | 2 | Channel of the request (0 current, 1 voltage, 2 temperature) |
| convDone | input | 1 | Converter finished, result valid |
| convResult | input | RES_W | Two's complement conversion result |
| modeState | output | 1 | Current mode bit |
| runState | output | 1 | Current run bit |
| chargeAcc | output | ACC_W | Signed charge accumulator |
| convCount | output | CNT_W | Current conversion counter |
| curReg | output | RES_W | Current value, refreshed once per frame |
| voltReg | output | RES_W | Latest voltage result |
| tempReg | output | RES_W | Latest temperature result |

## Verification
The bench builds the block with TICKS_PER_SEC set to 16 and the time-base strobe on every second clock. A frame then lasts 128 clocks instead of millions, so several frame wraps and a complete four-frame temperature rotation fit into a few hundred cycles. FRAME_SEC, TEMP_EVERY and the widths keep their default values, so the slot ordering, the sign extension into the 32-bit accumulator and the once-per-frame refresh of the current register are exercised exactly as built.

// File: rtl/meas_seq_pkg.sv
package meas_seq_pkg;
  typedef enum logic [1:0] {
    CH_CUR  = 2'd0,
    CH_VOLT = 2'd1,
    CH_TEMP = 2'd2
  } chan_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accAdd;    // current result completes: accumulate and count
    logic voltLoad;  // voltage result completes
    logic tempLoad;  // temperature result completes
    logic curCopy;   // voltage slot launched: refresh visible current
    logic cntClear;  // zero the conversion counter
  } strobe_t;
endpackage

// File: rtl/meas_seq_ctrl.sv
module meas_seq_ctrl
  import meas_seq_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int FRAME_SEC     = 4,
  parameter int TEMP_EVERY    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       cfgWr,
  input  logic       cfgMode,
  input  logic       cfgRun,
  input  logic       cntClr,
  input  logic       convDone,
  output logic       convStart,
  output logic [1:0] convChan,
  output logic       modeState,
  output logic       runState,
  output strobe_t    strb
);
  localparam int FRAME_TICKS = TICKS_PER_SEC * FRAME_SEC;
  localparam int FT_W        = $clog2(FRAME_TICKS);
  localparam int TE_W        = (TEMP_EVERY > 1) ? $clog2(TEMP_EVERY) : 1;

  typedef enum logic {S_IDLE, S_BUSY} state_e;

  state_e          state;
  chan_e           chanQ, nextChan;
  logic            startQ, modeQ, runQ;
  logic            voltDue, tempDue;
  logic [FT_W-1:0] frameCnt;
  logic [TE_W-1:0] tempIdx;
  logic            launch, finish, frameWrap, tempWrap;

  assign frameWrap = runQ && tickEn && (frameCnt == FT_W'(FRAME_TICKS - 1));
  assign tempWrap  = frameWrap && (tempIdx == TE_W'(TEMP_EVERY - 1));
  assign finish    = (state == S_BUSY) && convDone;

  // slot choice: voltage, then temperature, then current in mixed mode
  always_comb begin
    launch   = 1'b0;
    nextChan = CH_CUR;
    if (state == S_IDLE && runQ) begin
      if (voltDue) begin
        launch   = 1'b1;
        nextChan = CH_VOLT;
      end else if (tempDue) begin
        launch   = 1'b1;
        nextChan = CH_TEMP;
      end else if (!modeQ) begin
        launch   = 1'b1;
        nextChan = CH_CUR;
      end
    end
  end

  always_comb begin
    strb.accAdd   = finish && runQ && (chanQ == CH_CUR);
    strb.voltLoad = finish && runQ && (chanQ == CH_VOLT);
    strb.tempLoad = finish && runQ && (chanQ == CH_TEMP);
    strb.curCopy  = launch && (nextChan == CH_VOLT);
    strb.cntClear = cntClr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      chanQ    <= CH_CUR;
      startQ   <= 1'b0;
      modeQ    <= 1'b1;
      runQ     <= 1'b0;
      voltDue  <= 1'b1;
      tempDue  <= 1'b0;
      frameCnt <= '0;
      tempIdx  <= '0;
    end else begin
      startQ <= launch;
      if (cfgWr) begin
        modeQ <= cfgMode;
        runQ  <= cfgRun;
      end
      if (runQ && tickEn)
        frameCnt <= frameWrap ? '0 : frameCnt + 1'b1;
      if (frameWrap)
        tempIdx <= tempWrap ? '0 : tempIdx + 1'b1;
      if (frameWrap)
        voltDue <= 1'b1;
      else if (launch && nextChan == CH_VOLT)
        voltDue <= 1'b0;
      if (tempWrap)
        tempDue <= 1'b1;
      else if (launch && nextChan == CH_TEMP)
        tempDue <= 1'b0;
      if (launch) begin
        state <= S_BUSY;
        chanQ <= nextChan;
      end else if (finish) begin
        state <= S_IDLE;
      end
    end
  end

  assign convStart = startQ;
  assign convChan  = chanQ;
  assign modeState = modeQ;
  assign runState  = runQ;
endmodule

// File: rtl/meas_seq_dp.sv
module meas_seq_dp
  import meas_seq_pkg::*;
#(
  parameter int RES_W = 16,
  parameter int ACC_W = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [RES_W-1:0] convResult,
  output logic [ACC_W-1:0] chargeAcc,
  output logic [CNT_W-1:0] convCount,
  output logic [RES_W-1:0] curReg,
  output logic [RES_W-1:0] voltReg,
  output logic [RES_W-1:0] tempReg
);
  localparam int EXT_W = ACC_W - RES_W;

  logic [ACC_W-1:0] accQ, resExt;
  logic [CNT_W-1:0] cntQ;
  logic [RES_W-1:0] lastCur, curQ, voltQ, tempQ;
  logic             curFresh;

  assign resExt = {{EXT_W{convResult[RES_W-1]}}, convResult};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ     <= '0;
      cntQ     <= '0;
      lastCur  <= '0;
      curFresh <= 1'b0;
      curQ     <= '0;
      voltQ    <= '0;
      tempQ    <= '0;
    end else begin
      if (strb.accAdd) begin
        accQ     <= accQ + resExt;
        lastCur  <= convResult;
        curFresh <= 1'b1;
      end else if (strb.curCopy) begin
        curFresh <= 1'b0;
      end
      if (strb.curCopy && curFresh)
        curQ <= lastCur;
      if (strb.cntClear)
        cntQ <= '0;
      else if (strb.accAdd)
        cntQ <= cntQ + 1'b1;
      if (strb.voltLoad)
        voltQ <= convResult;
      if (strb.tempLoad)
        tempQ <= convResult;
    end
  end

  assign chargeAcc = accQ;
  assign convCount = cntQ;
  assign curReg    = curQ;
  assign voltReg   = voltQ;
  assign tempReg   = tempQ;
endmodule

// File: rtl/meas_sequencer.sv
module meas_sequencer
  import meas_seq_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int FRAME_SEC     = 4,
  parameter int TEMP_EVERY    = 4,
  parameter int RES_W         = 16,
  parameter int ACC_W         = 32,
  parameter int CNT_W         = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             cfgWr,
  input  logic             cfgMode,
  input  logic             cfgRun,
  input  logic             cntClr,
  output logic             convStart,
  output logic [1:0]       convChan,
  input  logic             convDone,
  input  logic [RES_W-1:0] convResult,
  output logic             modeState,
  output logic             runState,
  output logic [ACC_W-1:0] chargeAcc,
  output logic [CNT_W-1:0] convCount,
  output logic [RES_W-1:0] curReg,
  output logic [RES_W-1:0] voltReg,
  output logic [RES_W-1:0] tempReg
);
  strobe_t strb;

  meas_seq_ctrl #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .FRAME_SEC    (FRAME_SEC),
    .TEMP_EVERY   (TEMP_EVERY)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .cfgWr    (cfgWr),
    .cfgMode  (cfgMode),
    .cfgRun   (cfgRun),
    .cntClr   (cntClr),
    .convDone (convDone),
    .convStart(convStart),
    .convChan (convChan),
    .modeState(modeState),
    .runState (runState),
    .strb     (strb)
  );

  meas_seq_dp #(
    .RES_W(RES_W),
    .ACC_W(ACC_W),
    .CNT_W(CNT_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .convResult(convResult),
    .chargeAcc (chargeAcc),
    .convCount (convCount),
    .curReg    (curReg),
    .voltReg   (voltReg),
    .tempReg   (tempReg)
  );
endmodule

// File: rtl/meas_seq_chk.sv
module meas_seq_chk #(
  parameter int RES_W = 16,
  parameter int ACC_W = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntClr,
  input logic             convStart,
  input logic [1:0]       convChan,
  input logic             convDone,
  input logic             modeState,
  input logic             runState,
  input logic [ACC_W-1:0] chargeAcc,
  input logic [CNT_W-1:0] convCount,
  input logic [RES_W-1:0] curReg
);
  p_start_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  p_chan_code_r11: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> convChan != 2'd3);

  p_no_cur_saving_r5: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && $past(modeState)) |-> convChan != 2'd0);

  p_no_start_standby_r9: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> $past(runState));

  p_acc_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !runState |=> $stable(chargeAcc));

  p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!runState && !cntClr) |=> $stable(convCount));

  p_cnt_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    cntClr |=> convCount == '0);

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    !cntClr |=> (convCount == $past(convCount)) ||
                (convCount == $past(convCount) + 1'b1));

  // the visible current value moves only when a voltage slot is launched
  p_cur_on_volt_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(convStart && convChan == 2'd1) |-> $stable(curReg));
endmodule

bind meas_sequencer meas_seq_chk #(
  .RES_W(RES_W),
  .ACC_W(ACC_W),
  .CNT_W(CNT_W)
) chk_i (.*);

// File: tb/meas_sequencer_tb.sv
module meas_sequencer_tb_top;
  localparam int TPS   = 16;
  localparam int RES_W = 16;
  localparam int ACC_W = 32;
  localparam int CNT_W = 16;
  localparam int FRAME_CLK = 4 * TPS * 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             tickEn = 1'b0;
  logic             cfgWr = 1'b0, cfgMode = 1'b0, cfgRun = 1'b0, cntClr = 1'b0;
  logic             convStart;
  logic [1:0]       convChan;
  logic             convDone = 1'b0;
  logic [RES_W-1:0] convResult = '0;
  logic             modeState, runState;
  logic [ACC_W-1:0] chargeAcc;
  logic [CNT_W-1:0] convCount;
  logic [RES_W-1:0] curReg, voltReg, tempReg;

  int nChk = 0, nErr = 0;

  // bench model
  logic [ACC_W-1:0] expAcc = '0;
  logic [CNT_W-1:0] expCnt = '0;
  logic [RES_W-1:0] lastCur = '0, expCur = '0, lastVolt = '0, lastTemp = '0;
  logic [RES_W-1:0] pendVal = '0;
  bit   fresh = 0, busy = 0, keepR = 0, prevKept = 0, curSeen = 0;
  int   latLeft = 0, gap = 0, seqIdx = 0, prevChan = -1, lastStart = -1;
  int   nCur = 0, nVolt = 0, nTemp = 0, nStarts = 0;
  logic [1:0] busyChan = 2'd0;

  always #2 clk = ~clk;
  always @(negedge clk) tickEn <= ~tickEn;

  meas_sequencer #(
    .TICKS_PER_SEC(TPS), .FRAME_SEC(4), .TEMP_EVERY(4),
    .RES_W(RES_W), .ACC_W(ACC_W), .CNT_W(CNT_W)
  ) dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cfgWr(cfgWr), .cfgMode(cfgMode),
    .cfgRun(cfgRun), .cntClr(cntClr), .convStart(convStart), .convChan(convChan),
    .convDone(convDone), .convResult(convResult), .modeState(modeState),
    .runState(runState), .chargeAcc(chargeAcc), .convCount(convCount),
    .curReg(curReg), .voltReg(voltReg), .tempReg(tempReg)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [RES_W-1:0] resFor(input logic [1:0] ch, input int i);
    if (ch == 2'd0) return (i % 3 == 0) ? RES_W'(-(120 + i * 7)) : RES_W'(310 + i * 5);
    if (ch == 2'd1) return RES_W'(16'h0600 + i);
    return RES_W'(16'h0020 + i);
  endfunction

  // converter model and on-the-fly sequence checks
  initial begin
    forever begin
      @(negedge clk);
      if (convDone) begin
        convDone = 1'b0;
        if (keepR) begin
          if (busyChan == 2'd0) begin
            expAcc  = expAcc + {{(ACC_W-RES_W){pendVal[RES_W-1]}}, pendVal};
            expCnt  = expCnt + 1'b1;
            lastCur = pendVal;
            fresh   = 1;
          end else if (busyChan == 2'd1) lastVolt = pendVal;
          else lastTemp = pendVal;
        end
        prevKept = keepR;
        gap = 0;
      end else if (busy) begin
        latLeft--;
        if (latLeft == 0) begin
          seqIdx++;
          pendVal    = resFor(busyChan, seqIdx);
          convResult = pendVal;
          convDone   = 1'b1;
          keepR      = runState;
          busy       = 0;
        end
      end else if (convStart) begin
        chk(convChan != 2'd3, "R11 channel code", convChan, 0);
        chk(!(modeState && convChan == 2'd0), "R5 current start in saving mode", convChan, 1);
        if (prevKept && !modeState && runState)
          chk(gap == 0, "R2 back-to-back start gap", gap, 0);
        if (convChan == 2'd2)
          chk(prevChan == 1, "R4 temperature follows voltage", prevChan, 1);
        if (prevChan == 2 && !modeState)
          chk(convChan == 2'd0, "R4 current resumes after temperature", convChan, 0);
        if (convChan == 2'd1 && fresh) begin
          expCur = lastCur;
          fresh  = 0;
        end
        chk(curReg == expCur, "R7 current register refresh", curReg, expCur);
        prevKept = 0;
        busy     = 1;
        busyChan = convChan;
        latLeft  = (convChan == 2'd0) ? TPS : TPS / 2;
        prevChan = convChan;
        lastStart = convChan;
        nStarts++;
        if (convChan == 2'd0) begin nCur++; curSeen = 1; end
        else if (convChan == 2'd1) nVolt++;
        else nTemp++;
      end else begin
        gap++;
      end
      if (!runState) prevKept = 0;
    end
  end

  task automatic setCfg(input bit m, input bit r);
    @(negedge clk);
    cfgMode = m; cfgRun = r; cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic stopMixed();
    curSeen = 0;
    wait (curSeen);
    @(negedge clk);
    cfgRun = 1'b0; cfgMode = modeState; cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic stopIdle();
    wait (!busy && !convDone && gap >= 3);
    setCfg(1'b1, 1'b0);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(modeState == 1'b1, "R1 mode after reset", modeState, 1);
    chk(runState == 1'b0, "R1 run after reset", runState, 0);
    chk(chargeAcc == '0 && convCount == '0, "R1 accumulator/counter", chargeAcc, 0);
    chk(curReg == '0 && voltReg == '0 && tempReg == '0, "R1 result registers", voltReg, 0);
    repeat (300) @(negedge clk);
    chk(nStarts == 0, "R9 no start in standby after reset", nStarts, 0);
  endtask

  task automatic t_mixed();
    setCfg(1'b0, 1'b1);
    wait (nStarts > 0);
    @(negedge clk);
    chk(lastStart == 1, "R3 first conversion is voltage", lastStart, 1);
    repeat (5 * FRAME_CLK + 40) @(negedge clk);
    stopMixed();
    chk(chargeAcc == expAcc, "R6 accumulator", chargeAcc, expAcc);
    chk(convCount == expCnt, "R6 counter (R9 discard included)", convCount, expCnt);
    chk(nVolt >= 5 && nVolt <= 7, "R3 voltage slots per frames", nVolt, 6);
    chk(nTemp == 1, "R4 one temperature slot in four frames", nTemp, 1);
    chk(voltReg == lastVolt, "R8 voltage register", voltReg, lastVolt);
    chk(tempReg == lastTemp, "R8 temperature register", tempReg, lastTemp);
    chk(curReg == expCur, "R7 current register held", curReg, expCur);
  endtask

  task automatic t_saving();
    int c0, v0;
    logic [ACC_W-1:0] a0;
    logic [CNT_W-1:0] n0;
    c0 = nCur; v0 = nVolt; a0 = chargeAcc; n0 = convCount;
    setCfg(1'b1, 1'b1);
    repeat (3 * FRAME_CLK + 20) @(negedge clk);
    stopIdle();
    chk(nCur == c0, "R5 no current conversions", nCur, c0);
    chk(chargeAcc == a0 && convCount == n0, "R5 accumulator and counter unchanged", chargeAcc, a0);
    chk(nVolt - v0 >= 2, "R3 voltage slots in saving mode", nVolt - v0, 3);
    chk(voltReg == lastVolt, "R8 voltage register in saving mode", voltReg, lastVolt);
  endtask

  task automatic t_standby();
    int s0;
    logic [ACC_W-1:0] a0;
    logic [CNT_W-1:0] n0;
    s0 = nStarts; a0 = chargeAcc; n0 = convCount;
    repeat (3 * FRAME_CLK) @(negedge clk);
    chk(nStarts == s0, "R9 no starts in standby", nStarts, s0);
    chk(chargeAcc == a0, "R9 accumulator holds", chargeAcc, a0);
    chk(convCount == n0, "R9 counter holds", convCount, n0);
  endtask

  task automatic t_clear();
    logic [ACC_W-1:0] a0;
    a0 = chargeAcc;
    @(negedge clk);
    cntClr = 1'b1;
    @(negedge clk);
    cntClr = 1'b0;
    expCnt = '0;
    chk(convCount == '0, "R10 counter cleared", convCount, 0);
    chk(chargeAcc == a0, "R10 accumulator untouched", chargeAcc, a0);
  endtask

  task automatic t_mixed_again();
    setCfg(1'b0, 1'b1);
    repeat (FRAME_CLK + 30) @(negedge clk);
    stopMixed();
    chk(convCount == expCnt, "R6 counter after clear", convCount, expCnt);
    chk(chargeAcc == expAcc, "R6 accumulator keeps sum", chargeAcc, expAcc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_mixed();
    t_saving();
    t_standby();
    t_clear();
    t_mixed_again();
    $display("CHECKS %0d ERRORS %0d", nChk, nErr);
    $finish;
  end
endmodule